// File: doc/BRIEF.md
# Staggered Multi-Bank Refresh Scheduler

The block decides which of four DRAM banks take part in each refresh operation. A base timer outside the block sends a one-clock refresh request pulse at a fixed interval. Bank 0 is refreshed on every request, because its rate is fixed by a display that also reads it. Banks 1, 2 and 3 are refreshed once per frame of L requests. Each of them has its own slot in the frame, so a refresh cycle never loads more than two banks at once and the supply current peaks are spread out.

Each request produces a registered result one clock later. The result is a 4-bit bank enable vector, the row address of every enabled bank, and the frame slot the request fell into, all qualified by a strobe. The frame length comes from an input and is taken up only at a frame boundary. The secondary slot positions are parameters. Elaboration stops if a position lies outside the largest frame or if two secondary banks share a slot. If the frame in use is too short to contain a secondary bank's slot, a flag reports it.

Top module: `refresh_stagger_sched`

## Requirements
- R1: A slot counter is 0 after reset and advances by one on each request pulse. It wraps from L-1 to 0. Cycles without a request leave it unchanged. Each strobe reports the slot the request occupied on `ref_slot`.
- R2: Bit 0 of `ref_bank_en` (bank 0) is set on every strobe.
- R3: For k = 1..3, bit k of `ref_bank_en` is set exactly when the reported slot equals that bank's position parameter (defaults: bank 1 at 0, bank 2 at 2, bank 3 at 6). With a 9-slot frame, slots 1, 3, 4, 5, 7 and 8 give 4'b0001.
- R4: No strobe has more than one of bits 3..1 of `ref_bank_en` set.
- R5: The frame length in use is DEF_FRAME (9) after reset. `frame_len` is sampled only on the request that wraps the counter back to 0, so a change made mid-frame has no effect on the current frame. A value of 0 is taken as 1, and a value above MAX_FRAME is taken as MAX_FRAME.
- R6: `ref_stb` is high for exactly the one clock after each request pulse. While `ref_stb` is low, `ref_bank_en`, `ref_rows` and `ref_slot` are zero.
- R7: Each bank has a ROW_W-bit row counter that is 0 after reset, is reported in `ref_rows[k*ROW_W +: ROW_W]` when that bank is enabled (0 otherwise), and steps by one, wrapping, after each refresh of that bank only.
- R8: `cfg_err`, as seen with a strobe, is 1 when the frame length that governed the reported slot is at most some secondary position. A bank in that situation is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_req | input | 1 | One-clock refresh request from the base timer |
| frame_len | input | SLOT_W | Requested frame length, taken at frame wrap |
| ref_stb | output | 1 | Result valid strobe, one clock per request |
| ref_bank_en | output | 4 | Banks refreshed by this request, bit k = bank k |
| ref_rows | output | 4*ROW_W | Row address per bank, bank k at bits k*ROW_W |
| ref_slot | output | SLOT_W | Frame slot of this request |
| cfg_err | output | 1 | Active frame excludes a secondary slot |

## Verification
A wrong slot count shows up on the very next strobe, as a shifted `ref_slot` and a secondary enable in the wrong place. A frame length taken at the wrong moment shows up within one frame, as the wrap occurring at the wrong slot. A row counter that steps at the wrong time appears as a wrong `ref_rows` field at that bank's next refresh, which for a secondary bank can be up to a whole frame later. The bench therefore keeps an arithmetic model of slot, active length and all four rows, and it compares every field on every strobe and on the idle cycles between strobes.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned NUM_SEC   = NUM_BANKS - 1;

  typedef logic [NUM_BANKS-1:0] bank_vec_t;
  typedef int unsigned sec_pos_t [0:NUM_SEC-1];
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int unsigned MAX_FRAME = 15,
  parameter int unsigned DEF_FRAME = 9,
  parameter int unsigned SLOT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [SLOT_W-1:0] frame_len,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] active_len
);
  localparam logic [SLOT_W-1:0] MAX_L = SLOT_W'(MAX_FRAME);
  localparam logic [SLOT_W-1:0] DEF_L = SLOT_W'(DEF_FRAME);
  localparam logic [SLOT_W-1:0] ONE_L = SLOT_W'(1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] len_q;
  logic [SLOT_W-1:0] len_next;
  logic              at_last;

  always_comb begin
    if (frame_len == '0)        len_next = ONE_L;
    else if (frame_len > MAX_L) len_next = MAX_L;
    else                        len_next = frame_len;
  end

  assign at_last = (slot_q == len_q - ONE_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      len_q  <= DEF_L;
    end else if (advance) begin
      if (at_last) begin
        slot_q <= '0;
        len_q  <= len_next;
      end else begin
        slot_q <= slot_q + ONE_L;
      end
    end
  end

  assign slot       = slot_q;
  assign active_len = len_q;

  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    slot_q < len_q); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (advance && at_last) |=> (slot_q == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(slot_q)); // R1
  AST_LEN_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(len_q) |-> (slot_q == '0)); // R5
endmodule

// File: rtl/slot_map_decode.sv
module slot_map_decode
  import refresh_sched_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 15,
  parameter int unsigned SLOT_W    = $clog2(MAX_FRAME + 1),
  parameter sec_pos_t    SEC_POS   = '{0, 2, 6}
) (
  input  logic [SLOT_W-1:0]  slot,
  input  logic [SLOT_W-1:0]  active_len,
  output bank_vec_t          sel,
  output logic [NUM_SEC-1:0] excluded
);
  assign sel[0] = 1'b1;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    localparam logic [SLOT_W-1:0] POS = SLOT_W'(SEC_POS[s]);

    if (SEC_POS[s] >= MAX_FRAME) begin : g_range_bad
      $error("secondary slot position outside largest frame");
    end
    for (genvar t = s + 1; t < NUM_SEC; t++) begin : g_dup
      if (SEC_POS[s] == SEC_POS[t]) begin : g_dup_bad
        $error("two secondary banks share a slot");
      end
    end

    assign sel[s+1]    = (slot == POS);
    assign excluded[s] = (POS >= active_len);
  end
endmodule

// File: rtl/bank_row_ctr.sv
module bank_row_ctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst)       row_q <= '0;
    else if (step) row_q <= row_q + ROW_W'(1);
  end

  assign row = row_q;

  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(row_q)); // R7
endmodule

// File: rtl/refresh_stagger_sched.sv
module refresh_stagger_sched
  import refresh_sched_pkg::*;
#(
  parameter int unsigned ROW_W     = 9,
  parameter int unsigned MAX_FRAME = 15,
  parameter int unsigned DEF_FRAME = 9,
  parameter sec_pos_t    SEC_POS   = '{0, 2, 6},
  parameter int unsigned SLOT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       refresh_req,
  input  logic [SLOT_W-1:0]          frame_len,
  output logic                       ref_stb,
  output logic [NUM_BANKS-1:0]       ref_bank_en,
  output logic [NUM_BANKS*ROW_W-1:0] ref_rows,
  output logic [SLOT_W-1:0]          ref_slot,
  output logic                       cfg_err
);
  logic [SLOT_W-1:0]  slot;
  logic [SLOT_W-1:0]  active_len;
  bank_vec_t          sel;
  logic [NUM_SEC-1:0] excluded;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_now;

  logic                            stb_q;
  bank_vec_t                       en_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows_q;
  logic [SLOT_W-1:0]               slot_q;
  logic                            err_q;

  slot_sequencer #(
    .MAX_FRAME (MAX_FRAME),
    .DEF_FRAME (DEF_FRAME),
    .SLOT_W    (SLOT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .advance    (refresh_req),
    .frame_len  (frame_len),
    .slot       (slot),
    .active_len (active_len)
  );

  slot_map_decode #(
    .MAX_FRAME (MAX_FRAME),
    .SLOT_W    (SLOT_W),
    .SEC_POS   (SEC_POS)
  ) u_map (
    .slot       (slot),
    .active_len (active_len),
    .sel        (sel),
    .excluded   (excluded)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_row_ctr #(.ROW_W(ROW_W)) u_row (
      .clk  (clk),
      .rst  (rst),
      .step (refresh_req & sel[b]),
      .row  (row_now[b])
    );

    always_ff @(posedge clk) begin
      if (rst)                       rows_q[b] <= '0;
      else if (refresh_req && sel[b]) rows_q[b] <= row_now[b];
      else                           rows_q[b] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= 1'b0;
      en_q   <= '0;
      slot_q <= '0;
      err_q  <= 1'b0;
    end else begin
      stb_q  <= refresh_req;
      en_q   <= refresh_req ? sel : '0;
      slot_q <= refresh_req ? slot : '0;
      err_q  <= |excluded;
    end
  end

  assign ref_stb     = stb_q;
  assign ref_bank_en = en_q;
  assign ref_rows    = rows_q;
  assign ref_slot    = slot_q;
  assign cfg_err     = err_q;

  AST_BANK0_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    ref_stb |-> ref_bank_en[0]); // R2
  AST_ONE_SECONDARY: assert property (@(posedge clk) disable iff (rst)
    $countones(ref_bank_en[NUM_BANKS-1:1]) <= 1); // R4
  AST_STB_LATENCY: assert property (@(posedge clk) disable iff (rst)
    refresh_req |=> ref_stb); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ref_stb |-> (ref_bank_en == '0 && ref_rows == '0 && ref_slot == '0)); // R6
  AST_EXCLUDED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (sel & {excluded, 1'b0}) == '0); // R8
endmodule

// File: tb/sim_refresh_stagger_sched.sv
module sim_refresh_stagger_sched;
  localparam int ROW_W = 4;
  localparam int MAXF  = 12;
  localparam int SW    = 4;
  localparam int NB    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             refresh_req = 1'b0;
  logic [SW-1:0]    frame_len = SW'(9);
  logic             ref_stb;
  logic [NB-1:0]    ref_bank_en;
  logic [NB*ROW_W-1:0] ref_rows;
  logic [SW-1:0]    ref_slot;
  logic             cfg_err;

  int checks = 0;
  int errors = 0;
  int m_slot, m_len;
  int m_row [NB];
  int pos [3] = '{0, 2, 6};

  always #10 clk = ~clk;

  refresh_stagger_sched #(
    .ROW_W(ROW_W), .MAX_FRAME(MAXF), .DEF_FRAME(9), .SEC_POS('{0, 2, 6}), .SLOT_W(SW)
  ) u0 (
    .clk(clk), .rst(rst), .refresh_req(refresh_req), .frame_len(frame_len),
    .ref_stb(ref_stb), .ref_bank_en(ref_bank_en), .ref_rows(ref_rows),
    .ref_slot(ref_slot), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff_len(input int v);
    if (v == 0) return 1;
    if (v > MAXF) return MAXF;
    return v;
  endfunction

  function automatic int excl(input int len);
    for (int k = 0; k < 3; k++) if (pos[k] >= len) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    m_slot = 0;
    m_len  = 9;
    for (int k = 0; k < NB; k++) m_row[k] = 0;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " R6 strobe low"}, int'(ref_stb), 0);
    chk({tag, " R6 enables zero"}, int'(ref_bank_en), 0);
    chk({tag, " R6 rows zero"}, int'(ref_rows), 0);
    chk({tag, " R6 slot zero"}, int'(ref_slot), 0);
  endtask

  task automatic pulse(input int gap);
    int exp_en;
    int sec;
    @(negedge clk) refresh_req = 1'b1;
    @(negedge clk) refresh_req = 1'b0;
    exp_en = 1;
    for (int k = 1; k < NB; k++) if (m_slot == pos[k-1]) exp_en |= (1 << k);
    sec = 0;
    for (int k = 1; k < NB; k++) sec += int'(ref_bank_en[k]);
    chk("R6 strobe after request", int'(ref_stb), 1);
    chk("R2 bank0 enabled", int'(ref_bank_en[0]), 1);
    chk("R3 enable vector", int'(ref_bank_en), exp_en);
    chk("R4 at most one secondary", int'(sec <= 1), 1);
    chk("R1 reported slot", int'(ref_slot), m_slot);
    for (int k = 0; k < NB; k++)
      chk("R7 row field", int'(ref_rows[k*ROW_W +: ROW_W]),
          ((exp_en >> k) & 1) ? m_row[k] : 0);
    chk("R8 cfg_err", int'(cfg_err), excl(m_len));
    for (int k = 0; k < NB; k++)
      if ((exp_en >> k) & 1) m_row[k] = (m_row[k] + 1) % (1 << ROW_W);
    if (m_slot == m_len - 1) begin
      m_slot = 0;
      m_len  = eff_len(int'(frame_len));
    end else begin
      m_slot++;
    end
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check_idle("gap");
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("reset");
    chk("R8 cfg_err after reset", int'(cfg_err), 0);

    // three default frames, varying idle gaps (R1 R3)
    for (int i = 0; i < 27; i++) pulse(i % 3);

    // mid-frame length change, must wait for wrap (R5)
    for (int i = 0; i < 4; i++) pulse(1);
    frame_len = SW'(11);
    for (int i = 0; i < 30; i++) pulse(i % 2);

    // short frame hides bank 3 slot (R8)
    frame_len = SW'(5);
    for (int i = 0; i < 20; i++) pulse(0);

    // zero length treated as one (R5)
    frame_len = SW'(0);
    for (int i = 0; i < 10; i++) pulse(1);

    // over-range length clamps (R5)
    frame_len = SW'(14);
    for (int i = 0; i < 30; i++) pulse(0);

    // reset in mid-frame restores slot, rows and default length (R1 R7)
    frame_len = SW'(9);
    for (int i = 0; i < 3; i++) pulse(0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_reset();
    check_idle("mid reset");
    for (int i = 0; i < 12; i++) pulse(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule